// File: doc/BRIEF.md
# Scaled Add-Subtract Compare Unit

This block is a purely combinational 64-bit integer arithmetic stage. It takes a 7-bit function code and two 64-bit operands. It produces a 64-bit result, an overflow-trap flag and an invalid-function flag in the same cycle.

The block covers quadword (64-bit) and longword (32-bit) addition and subtraction. Each has a plain wrapping form and a form that raises the overflow flag. Operand A can be pre-scaled by 4 or by 8 before the add or subtract. The block also performs equality, signed and unsigned ordered compares, and an eight-lane bytewise unsigned greater-or-equal compare that returns a lane bitmask.

The surrounding pipeline chooses between register and literal for operand B, writes the result back, and turns the overflow flag into a trap. It can place this block directly between its operand latches and its result bus.

Top module: `scaled_arith_unit`

## Requirements
- R1: Quadword codes compute over all 64 bits with wraparound: 0x20 gives A+B, 0x29 gives A-B, 0x60 gives A+B and 0x69 gives A-B.
- R2: Longword codes take the low 32 bits of the operation and sign-extend bit 31 into bits 63:32. The codes are 0x00 (A+B), 0x09 (A-B), 0x40 (A+B) and 0x49 (A-B). Bits 63:32 of the operands have no effect on the result.
- R3: Scaled codes shift A left before the operation. The shift is 2 for 0x02, 0x22, 0x0b and 0x2b, and 3 for 0x12, 0x32, 0x1b and 0x3b. Codes 0x02, 0x12, 0x0b and 0x1b are longword adds or subtracts. Codes 0x22, 0x32, 0x2b and 0x3b are quadword adds or subtracts. Codes 0x0b, 0x1b, 0x2b and 0x3b subtract; the others add.
- R4: For codes 0x40 and 0x60, the overflow flag is 1 exactly when A and B have equal sign bits and the sign bit of the sum differs from that of A. The sign bit is bit 31 for longword codes and bit 63 for quadword codes.
- R5: For codes 0x49 and 0x69, the overflow flag is 1 exactly when the sign bits of A and B differ and the sign bit of the difference differs from that of A.
- R6: The overflow flag is 0 for every code other than 0x40, 0x60, 0x49 and 0x69. When the flag is 1, the result still carries the wrapped value.
- R7: The compare codes put 1 or 0 in the result, with bits 63:1 zero. Code 0x2d tests A==B. Code 0x6d tests signed A<=B and 0x4d tests signed A<B. Code 0x3d tests unsigned A<=B and 0x1d tests unsigned A<B.
- R8: For code 0x0f, result bit i (i = 0..7) is 1 when byte i of A (bits 8i+7:8i) is unsigned greater than or equal to byte i of B. Bits 63:8 of the result are zero.
- R9: Any code not listed in R1 to R8 sets the invalid-function flag to 1 and drives a result of zero and an overflow flag of 0.
- R10: Every code listed in R1 to R8 drives the invalid-function flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | 7 | Function code selecting the operation |
| opnd_a | input | 64 | Operand A (scaled operand for scaled forms) |
| opnd_b | input | 64 | Operand B |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| bad_fn | output | 1 | Function code is not implemented |

## Verification
Immediate assertions in the RTL check several output properties whenever the inputs change. An invalid code always gives a zero result and no overflow. The overflow flag only appears with a trapping code. Compare results never carry bits above bit 0, and bytewise results never carry bits above bit 7. The upper half of a longword result always repeats bit 31. These properties cannot show that the arithmetic values or the overflow decisions are right. Only the bench's scenarios show that: they compare against wide-precision reference arithmetic on boundary operands at the 32-bit and 64-bit sign limits, on mixed-sign compares, on byte-lane ties, and on a sweep of all 128 codes.

// File: rtl/scaled_arith_unit.sv
module scaled_arith_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int FN_W   = 7
) (
  input  logic [FN_W-1:0]   fn_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap,
  output logic              bad_fn
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    K_NONE, K_ARITH, K_EQ, K_SLE, K_SLT, K_ULE, K_ULT, K_BYTES
  } kind_t;

  kind_t      kind;
  logic       is_sub, is_quad, traps;
  logic [1:0] shamt;

  always_comb begin
    kind    = K_ARITH;
    is_sub  = 1'b0;
    is_quad = 1'b0;
    traps   = 1'b0;
    shamt   = 2'd0;
    case (fn_code)
      7'h00: ;
      7'h40: traps = 1'b1;
      7'h02: shamt = 2'd2;
      7'h12: shamt = 2'd3;
      7'h20: is_quad = 1'b1;
      7'h60: begin is_quad = 1'b1; traps = 1'b1; end
      7'h22: begin is_quad = 1'b1; shamt = 2'd2; end
      7'h32: begin is_quad = 1'b1; shamt = 2'd3; end
      7'h09: is_sub = 1'b1;
      7'h49: begin is_sub = 1'b1; traps = 1'b1; end
      7'h0b: begin is_sub = 1'b1; shamt = 2'd2; end
      7'h1b: begin is_sub = 1'b1; shamt = 2'd3; end
      7'h29: begin is_sub = 1'b1; is_quad = 1'b1; end
      7'h69: begin is_sub = 1'b1; is_quad = 1'b1; traps = 1'b1; end
      7'h2b: begin is_sub = 1'b1; is_quad = 1'b1; shamt = 2'd2; end
      7'h3b: begin is_sub = 1'b1; is_quad = 1'b1; shamt = 2'd3; end
      7'h2d: kind = K_EQ;
      7'h6d: kind = K_SLE;
      7'h4d: kind = K_SLT;
      7'h3d: kind = K_ULE;
      7'h1d: kind = K_ULT;
      7'h0f: kind = K_BYTES;
      default: kind = K_NONE;
    endcase
  end

  logic [DATA_W-1:0] a_scaled, arith_raw, arith_res;
  logic              sa, sb, sr, ovf_hit;
  int unsigned       sidx;

  assign a_scaled  = opnd_a << shamt;
  assign arith_raw = is_sub ? (a_scaled - opnd_b) : (a_scaled + opnd_b);
  assign sidx      = is_quad ? DATA_W - 1 : HALF_W - 1;
  assign sa        = opnd_a[sidx];
  assign sb        = opnd_b[sidx];
  assign sr        = arith_raw[sidx];
  assign ovf_hit   = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  assign arith_res = is_quad ? arith_raw
                             : {{HALF_W{arith_raw[HALF_W-1]}}, arith_raw[HALF_W-1:0]};

  logic [LANES-1:0] lane_ge;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ge[g] = opnd_a[g*LANE_W +: LANE_W] >= opnd_b[g*LANE_W +: LANE_W];
  end

  logic c_eq, c_slt, c_ult;
  assign c_eq  = opnd_a == opnd_b;
  assign c_slt = $signed(opnd_a) < $signed(opnd_b);
  assign c_ult = opnd_a < opnd_b;

  always_comb begin
    result = '0;
    case (kind)
      K_ARITH: result = arith_res;
      K_EQ:    result[0] = c_eq;
      K_SLE:   result[0] = c_slt | c_eq;
      K_SLT:   result[0] = c_slt;
      K_ULE:   result[0] = c_ult | c_eq;
      K_ULT:   result[0] = c_ult;
      K_BYTES: result[LANES-1:0] = lane_ge;
      default: result = '0;
    endcase
  end

  assign ovf_trap = (kind == K_ARITH) && traps && ovf_hit;
  assign bad_fn   = kind == K_NONE;

  always_comb begin
    if (!$isunknown({fn_code, opnd_a, opnd_b})) begin
      assert_bad_quiet_R9: assert (!bad_fn || (result == '0 && !ovf_trap))
        else $error("invalid code drove nonzero outputs");
      assert_ovf_only_trap_R6: assert (!ovf_trap ||
          fn_code == 7'h40 || fn_code == 7'h60 || fn_code == 7'h49 || fn_code == 7'h69)
        else $error("overflow on non-trapping code");
      assert_cmp_bit_R7: assert (!(fn_code == 7'h2d || fn_code == 7'h6d || fn_code == 7'h4d ||
          fn_code == 7'h3d || fn_code == 7'h1d) || result[DATA_W-1:1] == '0)
        else $error("compare result above bit 0");
      assert_bytes_width_R8: assert (fn_code != 7'h0f || result[DATA_W-1:LANES] == '0)
        else $error("bytewise result above lane bits");
      assert_long_sext_R2: assert (kind != K_ARITH || is_quad ||
          result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})
        else $error("longword result not sign-extended");
      assert_valid_code_R10: assert (fn_code != 7'h0f || !bad_fn)
        else $error("bytewise code flagged invalid");
    end
  end
endmodule

// File: tb/test_scaled_arith_unit.sv
module test_scaled_arith_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  fn;
  logic [63:0] a, b;
  logic [63:0] res;
  logic        ovf, bad;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  scaled_arith_unit i_scaled_arith_unit (
    .fn_code(fn), .opnd_a(a), .opnd_b(b), .result(res), .ovf_trap(ovf), .bad_fn(bad)
  );

  function automatic string tag(input logic [6:0] f);
    case (f)
      7'h20, 7'h29: return "R1";
      7'h00, 7'h09: return "R2";
      7'h02, 7'h12, 7'h22, 7'h32, 7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R3";
      7'h40, 7'h60: return "R4";
      7'h49, 7'h69: return "R5";
      7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d: return "R7";
      7'h0f: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y,
                       output logic [63:0] r, output logic o, output logic v);
    longint sx, sy, ex;
    logic signed [65:0] wx, wy, wq;
    int mul;
    bit sub, quad, isar;
    r = 0; o = 0; v = 1; isar = 1; sub = 0; quad = 0; mul = 1;
    case (f)
      7'h00, 7'h40: ;
      7'h02: mul = 4;
      7'h12: mul = 8;
      7'h20, 7'h60: quad = 1;
      7'h22: begin quad = 1; mul = 4; end
      7'h32: begin quad = 1; mul = 8; end
      7'h09, 7'h49: sub = 1;
      7'h0b: begin sub = 1; mul = 4; end
      7'h1b: begin sub = 1; mul = 8; end
      7'h29, 7'h69: begin sub = 1; quad = 1; end
      7'h2b: begin sub = 1; quad = 1; mul = 4; end
      7'h3b: begin sub = 1; quad = 1; mul = 8; end
      default: isar = 0;
    endcase
    if (isar) begin
      if (quad) begin
        wx = $signed({{2{x[63]}}, x}); wy = $signed({{2{y[63]}}, y});
        wq = sub ? wx * mul - wy : wx * mul + wy;
        r = wq[63:0];
        if (f == 7'h60 || f == 7'h69)
          o = (wq > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (wq < -66'sh0_8000_0000_0000_0000);
      end else begin
        sx = longint'($signed(x[31:0])); sy = longint'($signed(y[31:0]));
        ex = sub ? sx * mul - sy : sx * mul + sy;
        r = {{32{ex[31]}}, ex[31:0]};
        if (f == 7'h40 || f == 7'h49)
          o = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
      end
    end else begin
      case (f)
        7'h2d: r = (x == y);
        7'h6d: r = ($signed(x) <= $signed(y));
        7'h4d: r = ($signed(x) < $signed(y));
        7'h3d: r = (x <= y);
        7'h1d: r = (x < y);
        7'h0f: for (int i = 0; i < 8; i++) r[i] = (x[8*i +: 8] >= y[8*i +: 8]);
        default: v = 0;
      endcase
    end
    v = !v;
  endtask

  task automatic apply(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] er; logic eo, eb;
    @(negedge clk);
    fn = f; a = x; b = y;
    @(posedge clk); #1;
    model(f, x, y, er, eo, eb);
    n_cmp++;
    if (res !== er || ovf !== eo || bad !== eb) begin
      n_bad++;
      $display("FAIL %s fn=%02h a=%016h b=%016h got res=%016h ovf=%0b bad=%0b exp res=%016h ovf=%0b bad=%0b",
               (ovf !== eo) ? ((f == 7'h49 || f == 7'h69) ? "R5" : (f == 7'h40 || f == 7'h60) ? "R4" : "R6")
               : (bad !== eb) ? ((eb) ? "R9" : "R10") : tag(f),
               f, x, y, res, ovf, bad, er, eo, eb);
    end
  endtask

  initial begin
    fn = 0; a = 0; b = 0;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (res !== 0 || ovf !== 0 || bad !== 0) begin
      n_bad++;
      $display("FAIL R2 reset state got res=%016h ovf=%0b bad=%0b exp 0 0 0", res, ovf, bad);
    end
    rst = 1'b0;
    apply(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);                 // R1 wrap
    apply(7'h29, 64'h0, 64'h1);                                   // R1 borrow
    apply(7'h00, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001); // R2 upper ignored
    apply(7'h09, 64'h0, 64'h1);                                   // R2 sign-extend
    apply(7'h02, 64'h4000_0001, 64'h3);                           // R3
    apply(7'h1b, 64'h1, 64'h9);                                   // R3
    apply(7'h32, 64'h2000_0000_0000_0000, 64'h5);                 // R3
    apply(7'h40, 64'h7FFF_FFFF, 64'h1);                           // R4 overflow
    apply(7'h40, 64'h8000_0000, 64'h8000_0000);                   // R4 overflow negative
    apply(7'h40, 64'h7FFF_FFFF, 64'hFFFF_FFFF);                   // R4 no overflow
    apply(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);                 // R4 quad overflow
    apply(7'h49, 64'h8000_0000, 64'h1);                           // R5 overflow
    apply(7'h49, 64'h8000_0000, 64'hFFFF_FFFF);                   // R5 none
    apply(7'h69, 64'h8000_0000_0000_0000, 64'h1);                 // R5 quad
    apply(7'h69, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000); // R5 quad
    apply(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);                 // R6 no flag
    apply(7'h22, 64'h4000_0000_0000_0000, 64'h0);                 // R6 no flag
    apply(7'h6d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);                 // R7 signed
    apply(7'h3d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);                 // R7 unsigned
    apply(7'h4d, 64'h5, 64'h5);                                   // R7
    apply(7'h6d, 64'h5, 64'h5);                                   // R7
    apply(7'h2d, 64'h5, 64'h5);                                   // R7
    apply(7'h0f, 64'h00FF_1080_0102_FF00, 64'h00FE_1180_0201_00FF); // R8
    apply(7'h7f, 64'hFFFF, 64'h1);                                // R9
    apply(7'h0f, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);                 // R10
    for (int f = 0; f < 128; f++) begin
      apply(7'(f), 64'h7FFF_FFFF_8000_0001, 64'hFFFF_FFFF_7FFF_FFFF);
      apply(7'(f), 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000);
      for (int k = 0; k < 6; k++)
        apply(7'(f), {$urandom, $urandom}, {$urandom, $urandom});
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule